// File: doc/BRIEF.md
# Single Set Bit Detector

This block looks at a parameterised input word and says whether exactly one of its bits is high. It also says whether the word is all zeros. Each input bit is turned into a small saturating tally with three states: nothing seen, one seen, and more than one seen. The tallies are merged in pairs down a balanced binary tree. The merge operator saturates at "more than one", so every node stays two bits wide whatever the word width is. The tree does not need a power-of-two width. At any level, a node left without a partner moves up to the next level unchanged.

A `PIPELINE` parameter selects one of two builds. The first is purely combinational. The second places a register after every second tree level and a register on the output flags. In that build a valid bit travels alongside the data, and the block takes a new word every cycle. Typical uses are checking a one-hot select or grant vector and flagging an empty request mask.

Top module: `single_bit_detect`

## Requirements
- R1: `exactly_one` is 1 for a word with exactly one bit set and 0 otherwise. This covers every bit position from 0 to WIDTH-1.
- R2: `is_zero` is 1 only when every bit of the word is 0.
- R3: Any word with two or more bits set gives `exactly_one`=0 and `is_zero`=0. This includes adjacent bits, the two end bits, and the all-ones word.
- R4: `exactly_one` and `is_zero` are never 1 in the same cycle.
- R5: A WIDTH that is not a power of two behaves as required by R1 to R3 for every input word.
- R6: With PIPELINE=0 the flags follow `in_word` with no clock edge involved, and `out_valid` equals `in_valid`.
- R7: With PIPELINE=1 the latency is L = (ceil(log2 WIDTH)-1)/2 + 1 clock edges, which is 3 for WIDTH=32. `out_valid` is `in_valid` delayed by L. A new word may be presented on every cycle, including after a cycle with `in_valid`=0.
- R8: With PIPELINE=1, while `rst_n` is low, `out_valid`, `exactly_one` and `is_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when PIPELINE=1 |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_word` as meaningful |
| in_word | input | WIDTH | Word under test |
| out_valid | output | 1 | Marks the flags as belonging to a valid word |
| exactly_one | output | 1 | High when exactly one bit of the word was set |
| is_zero | output | 1 | High when no bit of the word was set |

## Verification
Every value of a 7-bit combinational build is applied. That separates the three outcomes at a width where odd leftover nodes pass up the tree. Walking a single 1 through all 32 positions of the pipelined build proves that each leaf reaches the root. Pairs of set bits, including adjacent bits and the two end bits, catch a merge that fails to saturate. A mixed random stream with valid gaps checks the latency, the throughput and the valid alignment.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

   // Saturating tally encoding; code 2'b11 is never produced.
   typedef enum logic [1:0] {
      TC_NONE = 2'b00,
      TC_ONE  = 2'b01,
      TC_MANY = 2'b10
   } tcount_t;

   // Commutative saturating combine of two tallies.
   function automatic logic [1:0] tc_merge(input logic [1:0] a, input logic [1:0] b);
      if (a == TC_NONE) return b;
      if (b == TC_NONE) return a;
      return TC_MANY;
   endfunction

   // Number of tree nodes present at a given level for a given leaf count.
   function automatic int unsigned nodes_at(input int unsigned leaves, input int unsigned lvl);
      int unsigned n;
      n = leaves;
      for (int unsigned i = 0; i < lvl; i++) n = (n + 1) / 2;
      return n;
   endfunction

endpackage

// File: rtl/sbd_merge.sv
module sbd_merge
   import sbd_pkg::*;
(
   input  logic [1:0] lhs,
   input  logic [1:0] rhs,
   output logic [1:0] res
);
   assign res = tc_merge(lhs, rhs);
endmodule

// File: rtl/sbd_level.sv
module sbd_level #(
   parameter int unsigned IN_N = 2,
   localparam int unsigned OUT_N = (IN_N + 1) / 2
) (
   input  logic [2*IN_N-1:0]  nodes_in,
   output logic [2*OUT_N-1:0] nodes_out
);
   for (genvar i = 0; i < OUT_N; i++) begin : g_node
      if (2*i + 1 < IN_N) begin : g_pair
         sbd_merge u_merge (
            .lhs(nodes_in[4*i +: 2]),
            .rhs(nodes_in[4*i+2 +: 2]),
            .res(nodes_out[2*i +: 2])
         );
      end else begin : g_pass
         // odd leftover node moves up unchanged
         assign nodes_out[2*i +: 2] = nodes_in[4*i +: 2];
      end
   end
endmodule

// File: rtl/single_bit_detect.sv
module single_bit_detect
   import sbd_pkg::*;
#(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned PIPELINE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_word,
   output logic             out_valid,
   output logic             exactly_one,
   output logic             is_zero
);
   localparam int unsigned LEVELS  = (WIDTH < 2) ? 1 : $clog2(WIDTH);
   localparam int unsigned LATENCY = (PIPELINE != 0) ? (LEVELS - 1) / 2 + 1 : 0;

   initial begin
      if (WIDTH < 2)    $fatal(1, "single_bit_detect: WIDTH must be at least 2");
      if (PIPELINE > 1) $fatal(1, "single_bit_detect: PIPELINE must be 0 or 1");
   end

   // Leaf mapping: a 0 bit is TC_NONE, a 1 bit is TC_ONE.
   logic [2*WIDTH-1:0] leaves;
   for (genvar b = 0; b < WIDTH; b++) begin : g_leaf
      assign leaves[2*b +: 2] = in_word[b] ? TC_ONE : TC_NONE;
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int unsigned NI  = nodes_at(WIDTH, l);
      localparam int unsigned NO  = nodes_at(WIDTH, l + 1);
      localparam bit          CUT = (PIPELINE != 0) && (((l + 1) % 2) == 0) && (l + 1 < LEVELS);

      logic [2*NI-1:0] src;
      logic            src_v;
      logic [2*NO-1:0] nxt;
      logic [2*NO-1:0] cur_q;
      logic            cur_v;

      if (l == 0) begin : g_src
         assign src   = leaves;
         assign src_v = in_valid;
      end else begin : g_src
         assign src   = g_lvl[l-1].cur_q;
         assign src_v = g_lvl[l-1].cur_v;
      end

      sbd_level #(.IN_N(NI)) u_level (
         .nodes_in (src),
         .nodes_out(nxt)
      );

      if (CUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cur_q <= '0;
               cur_v <= 1'b0;
            end else begin
               cur_q <= nxt;
               cur_v <= src_v;
            end
         end
      end else begin : g_wire
         assign cur_q = nxt;
         assign cur_v = src_v;
      end
   end

   logic [1:0] root;
   logic       root_v;
   assign root   = g_lvl[LEVELS-1].cur_q;
   assign root_v = g_lvl[LEVELS-1].cur_v;

   if (PIPELINE != 0) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            exactly_one <= 1'b0;
            is_zero     <= 1'b0;
         end else begin
            out_valid   <= root_v;
            exactly_one <= (root == TC_ONE);
            is_zero     <= (root == TC_NONE);
         end
      end
   end else begin : g_out_comb
      assign out_valid   = root_v;
      assign exactly_one = (root == TC_ONE);
      assign is_zero     = (root == TC_NONE);
   end

endmodule

// File: rtl/sbd_chk.sv
module sbd_chk #(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned LATENCY = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [WIDTH-1:0] in_word,
   input logic             out_valid,
   input logic             exactly_one,
   input logic             is_zero
);
   logic ref_one, ref_zero;
   assign ref_one  = ($countones(in_word) == 1);
   assign ref_zero = (in_word == '0);

   assert_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(exactly_one && is_zero));

   if (LATENCY == 0) begin : g_comb
      assert_valid_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid);
      assert_one_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
         exactly_one == ref_one);
      assert_zero_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
         is_zero == ref_zero);
   end else begin : g_seq
      logic [LATENCY-1:0] sh_v, sh_one, sh_zero;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_v    <= '0;
            sh_one  <= '0;
            sh_zero <= '0;
         end else begin
            sh_v[0]    <= in_valid;
            sh_one[0]  <= ref_one;
            sh_zero[0] <= ref_zero;
            for (int i = 1; i < LATENCY; i++) begin
               sh_v[i]    <= sh_v[i-1];
               sh_one[i]  <= sh_one[i-1];
               sh_zero[i] <= sh_zero[i-1];
            end
         end
      end
      assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == sh_v[LATENCY-1]);
      assert_one_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (exactly_one == sh_one[LATENCY-1]));
      assert_zero_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (is_zero == sh_zero[LATENCY-1]));
   end
endmodule

bind single_bit_detect sbd_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (.*);

// File: tb/sim_single_bit_detect.sv
module sim_single_bit_detect;
   localparam int unsigned W0   = 32;
   localparam int unsigned W1   = 7;
   localparam int unsigned LAT0 = 3;  // R7: ($clog2(32)-1)/2 + 1

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;  // 250 MHz

   logic          v0 = 1'b0, ov0, one0, zero0;
   logic [W0-1:0] w0 = '0;
   logic          v1 = 1'b0, ov1, one1, zero1;
   logic [W1-1:0] w1 = '0;

   single_bit_detect #(.WIDTH(W0), .PIPELINE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v0), .in_word(w0),
      .out_valid(ov0), .exactly_one(one0), .is_zero(zero0));

   single_bit_detect #(.WIDTH(W1), .PIPELINE(0)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_word(w1),
      .out_valid(ov1), .exactly_one(one1), .is_zero(zero1));

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   logic [W0-1:0] sw [0:255];
   logic          sv [0:255];

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic [1:0] expect_flags(input logic [W0-1:0] w);
      return {($countones(w) == 1), (w == '0)};
   endfunction

   // Plays sw/sv[0..n-1] into u0 and checks each result L cycles later.
   task automatic run_stream(input string req, input int n);
      for (int i = 0; i < n + LAT0; i++) begin
         @(negedge clk);
         if (i >= LAT0) begin
            chk("R7 valid delay", {2'b00, ov0}, {2'b00, sv[i-LAT0]});
            if (sv[i-LAT0]) begin
               chk(req, {1'b0, one0, zero0}, {1'b0, expect_flags(sw[i-LAT0])});
               chk("R4 exclusive", {2'b00, one0 & zero0}, 3'b000);
            end
         end
         if (i < n) begin
            v0 = sv[i];
            w0 = sw[i];
         end else begin
            v0 = 1'b0;
            w0 = '0;
         end
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      v0 = 1'b1;
      w0 = 32'h1;
      repeat (3) @(negedge clk);
      chk("R8 reset state", {ov0, one0, zero0}, 3'b000);
      v0 = 1'b0;
      w0 = '0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_comb_exhaustive;
      for (int v = 0; v < (1 << W1); v++) begin
         w1 = v[W1-1:0];
         v1 = v[0];
         #1;
         chk("R5 R1 R2 R3 comb flags", {1'b0, one1, zero1},
             {1'b0, ($countones(w1) == 1), (w1 == '0)});
         chk("R6 comb valid", {2'b00, ov1}, {2'b00, v1});
         chk("R4 exclusive", {2'b00, one1 & zero1}, 3'b000);
      end
   endtask

   task automatic t_walking_one;
      for (int i = 0; i < W0; i++) begin
         sw[i] = '0;
         sw[i][i] = 1'b1;
         sv[i] = 1'b1;
      end
      run_stream("R1 walking one", W0);
   endtask

   task automatic t_many;
      int n = 0;
      for (int i = 0; i < W0 - 1; i++) begin
         sw[n] = '0; sw[n][i] = 1'b1; sw[n][i+1] = 1'b1; sv[n] = 1'b1; n++;
      end
      sw[n] = '0; sw[n][0] = 1'b1; sw[n][W0-1] = 1'b1; sv[n] = 1'b1; n++;
      sw[n] = '1; sv[n] = 1'b1; n++;
      sw[n] = '0; sv[n] = 1'b1; n++;  // R2 zero word
      sw[n] = 32'h8000_0001 | 32'h0001_0000; sv[n] = 1'b1; n++;
      run_stream("R3 R2 many and zero", n);
   endtask

   task automatic t_random_bubbles;
      for (int i = 0; i < 200; i++) begin
         case ($urandom_range(0, 3))
            0: sw[i] = '0;
            1: begin sw[i] = '0; sw[i][$urandom_range(0, W0-1)] = 1'b1; end
            2: begin sw[i] = '0; sw[i][$urandom_range(0, W0-1)] = 1'b1;
                     sw[i][$urandom_range(0, W0-1)] = 1'b1; end
            default: sw[i] = $urandom;
         endcase
         sv[i] = ($urandom_range(0, 4) != 0);
      end
      run_stream("R7 R1 R2 random stream", 200);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_comb_exhaustive();
      t_walking_one();
      t_many();
      t_random_bubbles();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule